// File: doc/BRIEF.md
# SIMD Variable Lane Blend Unit

This execution unit serves a SIMD register file whose registers are 256 bits wide. It takes a first source, a second source and a mask operand. It builds a destination value one 32-bit lane at a time. The only bit of a mask lane that matters is its top bit, bit 31: when that bit is set, the lane comes from the second source; when it is clear, the lane comes from the first source. Lane data is passed through bit-exact. No arithmetic is done on it and no floating-point exception can arise.

Three encodings are handled, and they differ in how they treat the upper half of the register:
- In the legacy 128-bit form, the destination is also the first source and the mask is always register 0. Bits 255:128 keep their old value.
- In the 128-bit extended form, the lower four lanes are blended and the upper half is zeroed.
- In the 256-bit extended form, all eight lanes are blended.

In both extended forms the mask register number comes from the upper nibble of an 8-bit immediate. The unit also detects undefined-opcode cases and suppresses the register write for them. The mask register index is driven combinationally to the register file read port, and the mask data is returned in the same cycle. The result, write enable, destination index and fault flag appear one clock after a valid request.

Top module: `lane_blend_unit`

## Requirements
- R1: For each 32-bit lane i (bits 32i+31:32i), the result lane equals the second source lane when mask bit 32i+31 is 1, and equals the first source lane when that bit is 0. The value is copied bit-exact.
- R2: In legacy mode (reqMode = 2'b00), maskRdIdx is 0. Lanes 0 to 3 are blended, and result bits 255:128 equal the first source's bits 255:128.
- R3: In 128-bit extended mode (reqMode = 2'b01), lanes 0 to 3 are blended and result bits 255:128 are zero.
- R4: In 256-bit extended mode (reqMode = 2'b10), all eight lanes are blended independently.
- R5: In the extended modes, maskRdIdx equals imm[7:4], and imm[3:0] has no effect on the index or on the result.
- R6: When core32 is 1, an extended-mode request drives maskRdIdx[3] to 0 whatever the value of imm[7]. Only registers 0 to 7 can then be selected.
- R7: A request faults in three cases: it is an extended-mode request with reqExtW = 1; it is a legacy request with reqExtPrefix = 1; or it uses the reserved mode 2'b11.
- R8: A faulting request gives outFault = 1 and outWe = 0 in its result cycle. A non-faulting request gives outWe = 1 and outFault = 0.
- R9: outValid, outWe, outFault, outData and outDstIdx reflect a request on the clock edge after it is presented. outDstIdx equals the request's dstIdx, and outValid is 0 in cycles that follow no request.
- R10: While rst is high at a clock edge, outValid, outWe and outFault are 0 after that edge, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 2 | 00 legacy 128, 01 extended 128, 10 extended 256, 11 reserved |
| reqExtW | input | 1 | W bit of the extended encoding |
| reqExtPrefix | input | 1 | Extended prefix present on a request |
| core32 | input | 1 | Core runs in 32-bit mode |
| imm | input | 8 | Immediate byte carrying the mask register number |
| dstIdx | input | 4 | Destination register number |
| srcA | input | 256 | First source (old destination in legacy mode) |
| srcB | input | 256 | Second source |
| maskRdIdx | output | 4 | Mask register read address |
| maskRdData | input | 256 | Mask register contents for maskRdIdx |
| outValid | output | 1 | Result strobe |
| outWe | output | 1 | Register file write enable |
| outFault | output | 1 | Undefined-opcode fault |
| outDstIdx | output | 4 | Destination register number of the result |
| outData | output | 256 | Result value |

## Verification
The mask patterns used are:
- All sign bits set and all clear. These separate a correct source order from a swapped one.
- Alternating lanes and a single walking lane. These expose lanes that are mixed up or wired to the wrong mask bit.
- Lanes whose sign bit is clear but whose other bits are all ones. These show that only bit 31 steers the choice.

Each pattern is run in all three modes against sources whose upper halves are non-zero, which tells keep, zero and blend apart. Immediates are varied in the low nibble and in bit 7 with and without core32, which isolates the index decode. Each fault combination is interleaved with good requests, back to back and with idle gaps, so that a stuck write enable or a lost strobe shows up.

// File: rtl/lane_blend_pkg.sv
package lane_blend_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_X128   = 2'b01,
    MODE_X256   = 2'b10,
    MODE_RSVD   = 2'b11
  } blendMode_e;

  typedef enum logic [1:0] {
    UP_KEEP  = 2'b00,
    UP_ZERO  = 2'b01,
    UP_BLEND = 2'b10
  } upperAct_e;

  typedef struct packed {
    logic      capture;
    logic      writeOk;
    logic      fault;
    upperAct_e upperAct;
  } ctrlStrobe_t;
endpackage

// File: rtl/blend_ctrl.sv
module blend_ctrl
  import lane_blend_pkg::*;
#(
  parameter int REG_IDX_W = 4
) (
  input  logic                 reqValid,
  input  logic [1:0]           reqMode,
  input  logic                 reqExtW,
  input  logic                 reqExtPrefix,
  input  logic                 core32,
  input  logic [7:0]           imm,
  output logic [REG_IDX_W-1:0] maskRdIdx,
  output ctrlStrobe_t          strobe
);
  localparam int TOP = REG_IDX_W - 1;

  blendMode_e mode;
  logic       badOp;
  logic [REG_IDX_W-1:0] immIdx;

  assign mode = blendMode_e'(reqMode);

  always_comb begin
    immIdx = imm[7 -: REG_IDX_W];
    if (core32) immIdx[TOP] = 1'b0;
  end

  always_comb begin
    badOp           = 1'b0;
    maskRdIdx       = immIdx;
    strobe.upperAct = UP_BLEND;
    unique case (mode)
      MODE_LEGACY: begin
        maskRdIdx       = '0;
        badOp           = reqExtPrefix;
        strobe.upperAct = UP_KEEP;
      end
      MODE_X128: begin
        badOp           = reqExtW;
        strobe.upperAct = UP_ZERO;
      end
      MODE_X256: badOp = reqExtW;
      default:   badOp = 1'b1;
    endcase
    strobe.capture = reqValid;
    strobe.fault   = badOp;
    strobe.writeOk = !badOp;
  end
endmodule

// File: rtl/blend_datapath.sv
module blend_datapath
  import lane_blend_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int LANES     = 8,
  parameter int REG_IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  logic [LANE_W*LANES-1:0]    srcA,
  input  logic [LANE_W*LANES-1:0]    srcB,
  input  logic [LANE_W*LANES-1:0]    maskData,
  input  logic [REG_IDX_W-1:0]       dstIdx,
  output logic                       outValid,
  output logic                       outWe,
  output logic                       outFault,
  output logic [REG_IDX_W-1:0]       outDstIdx,
  output logic [LANE_W*LANES-1:0]    outData
);
  localparam int WIDTH = LANE_W * LANES;
  localparam int HALF  = LANES / 2;

  logic [WIDTH-1:0] blendNext;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic             pickB;
    logic [LANE_W-1:0] laneA, laneB;
    assign pickB = maskData[l*LANE_W + LANE_W - 1];
    assign laneA = srcA[l*LANE_W +: LANE_W];
    assign laneB = srcB[l*LANE_W +: LANE_W];
    if (l < HALF) begin : gLow
      assign blendNext[l*LANE_W +: LANE_W] = pickB ? laneB : laneA;
    end else begin : gHigh
      always_comb begin
        unique case (strobe.upperAct)
          UP_KEEP:  blendNext[l*LANE_W +: LANE_W] = laneA;
          UP_ZERO:  blendNext[l*LANE_W +: LANE_W] = '0;
          default:  blendNext[l*LANE_W +: LANE_W] = pickB ? laneB : laneA;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outWe     <= 1'b0;
      outFault  <= 1'b0;
      outDstIdx <= '0;
      outData   <= '0;
    end else begin
      outValid <= strobe.capture;
      outWe    <= strobe.capture & strobe.writeOk;
      outFault <= strobe.capture & strobe.fault;
      if (strobe.capture) begin
        outDstIdx <= dstIdx;
        outData   <= blendNext;
      end
    end
  end
endmodule

// File: rtl/lane_blend_unit.sv
module lane_blend_unit
  import lane_blend_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int LANES     = 8,
  parameter int REG_IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic [1:0]              reqMode,
  input  logic                    reqExtW,
  input  logic                    reqExtPrefix,
  input  logic                    core32,
  input  logic [7:0]              imm,
  input  logic [REG_IDX_W-1:0]    dstIdx,
  input  logic [LANE_W*LANES-1:0] srcA,
  input  logic [LANE_W*LANES-1:0] srcB,
  output logic [REG_IDX_W-1:0]    maskRdIdx,
  input  logic [LANE_W*LANES-1:0] maskRdData,
  output logic                    outValid,
  output logic                    outWe,
  output logic                    outFault,
  output logic [REG_IDX_W-1:0]    outDstIdx,
  output logic [LANE_W*LANES-1:0] outData
);
  ctrlStrobe_t strobe;

  blend_ctrl #(.REG_IDX_W(REG_IDX_W)) uCtrl (
    .reqValid(reqValid), .reqMode(reqMode), .reqExtW(reqExtW),
    .reqExtPrefix(reqExtPrefix), .core32(core32), .imm(imm),
    .maskRdIdx(maskRdIdx), .strobe(strobe)
  );

  blend_datapath #(.LANE_W(LANE_W), .LANES(LANES), .REG_IDX_W(REG_IDX_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .srcA(srcA), .srcB(srcB),
    .maskData(maskRdData), .dstIdx(dstIdx), .outValid(outValid),
    .outWe(outWe), .outFault(outFault), .outDstIdx(outDstIdx), .outData(outData)
  );
endmodule

// File: rtl/lane_blend_check.sv
module lane_blend_check #(
  parameter int LANE_W    = 32,
  parameter int LANES     = 8,
  parameter int REG_IDX_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reqValid,
  input logic [1:0]              reqMode,
  input logic                    reqExtW,
  input logic                    reqExtPrefix,
  input logic                    core32,
  input logic [7:0]              imm,
  input logic [REG_IDX_W-1:0]    maskRdIdx,
  input logic                    outValid,
  input logic                    outWe,
  input logic                    outFault,
  input logic [LANE_W*LANES-1:0] outData
);
  localparam int WIDTH = LANE_W * LANES;

  AST_LEGACY_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reqMode == 2'b00) |-> (maskRdIdx == '0)); // R2

  AST_CORE32_LOW_BANK: assert property (@(posedge clk) disable iff (rst)
    (core32 && reqMode != 2'b00) |-> !maskRdIdx[REG_IDX_W-1]); // R6

  AST_EXT_W_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqMode == 2'b01 || reqMode == 2'b10) && reqExtW) |=> (outFault && !outWe)); // R7

  AST_PREFIX_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 2'b00 && reqExtPrefix) |=> (outFault && !outWe)); // R7

  AST_WE_EXCLUDES_FAULT: assert property (@(posedge clk) disable iff (rst)
    outFault |-> !outWe); // R8

  AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> outValid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!outValid && !outWe && !outFault)); // R9

  AST_X128_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode == 2'b01 && !reqExtW) |=> (outData[WIDTH-1:WIDTH/2] == '0)); // R3

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!outValid && !outWe && !outFault)); // R10
endmodule

bind lane_blend_unit lane_blend_check #(
  .LANE_W(LANE_W), .LANES(LANES), .REG_IDX_W(REG_IDX_W)
) uCheck (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqMode(reqMode), .reqExtW(reqExtW),
  .reqExtPrefix(reqExtPrefix), .core32(core32), .imm(imm), .maskRdIdx(maskRdIdx),
  .outValid(outValid), .outWe(outWe), .outFault(outFault), .outData(outData)
);

// File: tb/lane_blend_unit_test.sv
module lane_blend_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reqValid = 1'b0;
  logic [1:0]   reqMode = 2'b00;
  logic         reqExtW = 1'b0, reqExtPrefix = 1'b0, core32 = 1'b0;
  logic [7:0]   imm = 8'h00;
  logic [3:0]   dstIdx = 4'h0;
  logic [255:0] srcA = '0, srcB = '0;
  logic [3:0]   maskRdIdx;
  logic [255:0] maskRdData;
  logic         outValid, outWe, outFault;
  logic [3:0]   outDstIdx;
  logic [255:0] outData;

  logic [255:0] regFile [16];
  assign maskRdData = regFile[maskRdIdx];

  lane_blend_unit uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqMode(reqMode), .reqExtW(reqExtW),
    .reqExtPrefix(reqExtPrefix), .core32(core32), .imm(imm), .dstIdx(dstIdx),
    .srcA(srcA), .srcB(srcB), .maskRdIdx(maskRdIdx), .maskRdData(maskRdData),
    .outValid(outValid), .outWe(outWe), .outFault(outFault),
    .outDstIdx(outDstIdx), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curTag = "R10";
  string expTag = "R10";

  logic         eValid = 1'b0, eWe = 1'b0, eFault = 1'b0;
  logic [3:0]   eDst = '0;
  logic [255:0] eData = '0;

  function automatic logic [3:0] refIdx(logic [1:0] m, logic c32, logic [7:0] im);
    if (m == 2'b00) return 4'd0;
    return {c32 ? 1'b0 : im[7], im[6:4]};
  endfunction

  function automatic logic refFault(logic [1:0] m, logic w, logic pre);
    if (m == 2'b11) return 1'b1;
    if (m == 2'b00) return pre;
    return w;
  endfunction

  // Behavioural reference, updated on every clock edge
  always @(posedge clk) begin
    logic [255:0] msk;
    logic [255:0] res;
    cycles++;
    expTag = curTag;
    if (rst) begin
      eValid = 0; eWe = 0; eFault = 0;
    end else begin
      eValid = reqValid;
      eFault = reqValid && refFault(reqMode, reqExtW, reqExtPrefix);
      eWe    = reqValid && !refFault(reqMode, reqExtW, reqExtPrefix);
      if (reqValid) begin
        msk = regFile[refIdx(reqMode, core32, imm)];
        for (int l = 0; l < 8; l++) begin
          if (l < 4 || reqMode == 2'b10)
            res[l*32 +: 32] = msk[l*32+31] ? srcB[l*32 +: 32] : srcA[l*32 +: 32];
          else if (reqMode == 2'b00)
            res[l*32 +: 32] = srcA[l*32 +: 32];
          else
            res[l*32 +: 32] = 32'h0;
        end
        eData = res;
        eDst  = dstIdx;
      end
    end
  end

  task automatic compareOut();
    compared++;
    if (outValid !== eValid || outWe !== eWe || outFault !== eFault ||
        (eWe && (outData !== eData || outDstIdx !== eDst))) begin
      mismatched++;
      $display("FAIL %s: got v=%b we=%b f=%b dst=%h data=%h, expected v=%b we=%b f=%b dst=%h data=%h",
               expTag, outValid, outWe, outFault, outDstIdx, outData,
               eValid, eWe, eFault, eDst, eData);
    end
  endtask

  task automatic issue(input string tag, input logic v, input logic [1:0] m,
                       input logic w, input logic pre, input logic c32,
                       input logic [7:0] im, input logic [3:0] d,
                       input logic [255:0] a, input logic [255:0] b);
    @(negedge clk);
    compareOut();
    reqValid = v; reqMode = m; reqExtW = w; reqExtPrefix = pre; core32 = c32;
    imm = im; dstIdx = d; srcA = a; srcB = b; curTag = tag;
    #1;
    if (v) begin
      compared++;
      if (maskRdIdx !== refIdx(m, c32, im)) begin
        mismatched++;
        $display("FAIL %s: maskRdIdx got %h expected %h", tag, maskRdIdx, refIdx(m, c32, im));
      end
    end
  endtask

  task automatic idle(input string tag);
    issue(tag, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0, srcA, srcB);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  logic [255:0] pa, pb;

  initial begin
    for (int k = 0; k < 16; k++) regFile[k] = rnd256();
    regFile[0]  = {8{32'h8000_0000}};   // all signs set
    regFile[1]  = {8{32'h7FFF_FFFF}};   // signs clear, rest ones
    regFile[2]  = {4{32'h0, 32'hFFFF_FFFF}}; // alternating
    regFile[3]  = 256'h0;
    regFile[10] = {8{32'h8000_0001}};
    regFile[12] = {4{32'hFFFF_FFFF, 32'h0}};
    regFile[13] = {32'h8000_0000, 224'h0}; // only lane 7
    pa = rnd256(); pb = rnd256();

    // R10: reset dominates a request
    @(posedge clk);
    issue("R10", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00, 4'h3, pa, pb);
    issue("R10", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00, 4'h3, pa, pb);
    @(negedge clk); rst = 1'b0;
    idle("R10");
    idle("R9");

    // R1/R2: legacy mode with several masks held in register 0
    for (int k = 0; k < 4; k++) begin
      regFile[0] = (k == 0) ? {8{32'h8000_0000}} : (k == 1) ? {8{32'h7FFF_FFFF}}
                 : (k == 2) ? {4{32'h0, 32'hFFFF_FFFF}} : rnd256();
      issue("R2", 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'hF5, 4'(k + 4), rnd256(), rnd256());
      idle("R2");
    end
    regFile[0] = {8{32'h8000_0000}};

    // R3: 128-bit extended mode clears the upper half
    issue("R3", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h20, 4'h1, rnd256(), rnd256());
    issue("R3", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h00, 4'h2, rnd256(), rnd256());
    issue("R1", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h10, 4'h2, rnd256(), rnd256());

    // R4: all eight lanes, walking single lane and alternating masks
    for (int l = 0; l < 8; l++) begin
      regFile[14] = 256'h0;
      regFile[14][l*32+31] = 1'b1;
      issue("R4", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'hE0, 4'(l), rnd256(), rnd256());
    end
    issue("R4", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'hC0, 4'h9, rnd256(), rnd256());
    issue("R4", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'hD0, 4'h9, rnd256(), rnd256());
    issue("R1", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'h10, 4'hA, rnd256(), rnd256());

    // R5: low immediate nibble is ignored
    pa = rnd256(); pb = rnd256();
    for (int n = 0; n < 16; n += 5)
      issue("R5", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, {4'hA, 4'(n)}, 4'hB, pa, pb);
    issue("R5", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h2F, 4'hB, pa, pb);

    // R6: 32-bit core drops immediate bit 7
    issue("R6", 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 8'hA3, 4'hC, rnd256(), rnd256());
    issue("R6", 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 8'hD0, 4'hC, rnd256(), rnd256());
    issue("R6", 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 8'hF0, 4'hC, rnd256(), rnd256());
    issue("R6", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'hD0, 4'hC, rnd256(), rnd256());

    // R7/R8: fault cases interleaved with good requests
    issue("R7", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 8'h20, 4'h5, rnd256(), rnd256());
    issue("R8", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'h20, 4'h5, rnd256(), rnd256());
    issue("R7", 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 8'h20, 4'h6, rnd256(), rnd256());
    issue("R7", 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00, 4'h6, rnd256(), rnd256());
    issue("R8", 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 8'h00, 4'h6, rnd256(), rnd256());
    issue("R7", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'h20, 4'h7, rnd256(), rnd256());
    idle("R8");
    issue("R8", 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 8'h20, 4'h7, rnd256(), rnd256());

    // R9: back-to-back and gapped requests carry their own destination
    for (int k = 0; k < 6; k++) begin
      issue("R9", 1'b1, 2'(k % 3), 1'b0, 1'b0, 1'b0, 8'(k << 4), 4'(15 - k), rnd256(), rnd256());
      if (k % 2 == 1) idle("R9");
    end

    // R10: reset in mid-stream
    issue("R10", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00, 4'h1, rnd256(), rnd256());
    @(negedge clk); rst = 1'b1;
    idle("R10");
    idle("R10");
    @(negedge clk); rst = 1'b0;
    idle("R10");
    idle("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule